// File: doc/BRIEF.md
# Upper memory shadow region decoder

This block decides, for each CPU memory access, whether the access is served by on-board DRAM or is passed out to the expansion bus. The decision covers the 256 KB window from 0xC0000 to 0xFFFFF. The window is split into sixteen 16 KB slices. Each slice has one bit that claims its reads for DRAM and a separate bit that claims its writes. Any access below the window always stays in DRAM.

Software sets the claim bits through an indexed register pair on the I/O bus. It first writes a register number to the index port, then reads or writes the selected register through the data port. Three registers hold the claim bits:

- One register covers the 0xC0000 segment and another covers the 0xD0000 segment. Each gives four slices two bits apiece.
- A third register covers the 0xE0000 and 0xF0000 segments, each as a single 64 KB block.

Decode and read-back are combinational. Register writes take effect on the clock edge.

Top module: `shadow_window_top`

## Requirements
- R1: After reset all three control registers read 0x00, the index is 0x00, and every access at or above 0xC0000 goes to the external bus (mem_internal = 0).
- R2: An I/O write to address 0x0022 loads the index. An I/O read at 0x0022 returns the current index.
- R3: An I/O write to address 0x0024 stores the data into the register selected by the index; the new value governs decode from the next clock edge. An I/O read at 0x0024 returns that register. The implemented indices are 0x04 (0xC0000 segment), 0x05 (0xD0000 segment) and 0x06 (0xE0000/0xF0000 segments).
- R4: With any other index, a read at 0x0024 returns 0xFF and a write at 0x0024 changes no register.
- R5: In register 0x06, bit 0 makes reads of 0xE0000–0xEFFFF internal and bit 1 makes writes there internal.
- R6: In register 0x06, bit 2 makes reads of 0xF0000–0xFFFFF internal and bit 3 makes writes there internal.
- R7: In register 0x04, slice i (0..3) spans 0xC0000 + i×0x4000 for 16 KB; bit 2i makes its reads internal and bit 2i+1 makes its writes internal.
- R8: Register 0x05 controls the slices of 0xD0000–0xDFFFF with the same bit layout as R7.
- R9: Every access below 0xC0000, read or write, is internal.
- R10: Reads and writes are decoded separately. mem_internal follows mem_addr and mem_wr in the same cycle, without a clock.
- R11: io_rdata is 0x00 whenever io_rd is low, or when io_addr is neither 0x0022 nor 0x0024.
- R12: I/O writes to any address other than 0x0022 and 0x0024 change neither the index nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mem_addr | input | 20 | CPU memory address |
| mem_wr | input | 1 | 1 for a memory write, 0 for a read |
| mem_internal | output | 1 | 1 when the access goes to DRAM, 0 when it goes to the external bus |

## Verification
An I/O write is due one edge later: the register holds the new value after the rising edge that samples the strobe. Decode and I/O read-back are due in the same cycle as their inputs.

The bench drives every input on the falling edge. It samples combinational results 1 ns after driving them. It checks the effect of a register write only from the next falling edge onward, by which point one rising edge has passed.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    localparam int IOA_W = 16;
    localparam int DW    = 8;
    localparam int MA_W  = 20;
    localparam int NREG  = 3;
    localparam int SLICES_PER_SEG = 4;
    localparam int NSEG  = 4;
    localparam int NSLICE = NSEG * SLICES_PER_SEG;
    localparam int SLICE_BITS = $clog2(NSLICE);
    localparam int SLICE_LSB = 14;

    localparam logic [IOA_W-1:0] PORT_INDEX = 16'h0022;
    localparam logic [IOA_W-1:0] PORT_DATA  = 16'h0024;
    localparam logic [DW-1:0]    FIRST_IDX  = 8'h04;

    typedef enum logic [1:0] {SEG_C = 2'd0, SEG_D = 2'd1, SEG_E = 2'd2, SEG_F = 2'd3} seg_e;

    function automatic logic [DW-1:0] reg_index(int n);
        return FIRST_IDX + DW'(n);
    endfunction
endpackage

// File: rtl/shadow_ctrl_regs.sv
module shadow_ctrl_regs
    import shadow_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IOA_W-1:0] io_addr,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    io_rdata,
    output logic [DW-1:0]    ctrl_c,
    output logic [DW-1:0]    ctrl_d,
    output logic [DW-1:0]    ctrl_ef
);
    logic [DW-1:0] idx_q;
    logic [DW-1:0] regs_q [NREG];
    logic [NREG-1:0] hit;
    logic          wr_index, wr_data;
    logic [DW-1:0] sel_data;

    assign wr_index = io_wr && (io_addr == PORT_INDEX);
    assign wr_data  = io_wr && (io_addr == PORT_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n)        idx_q <= '0;
        else if (wr_index) idx_q <= io_wdata;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        assign hit[g] = (idx_q == reg_index(g));
        always_ff @(posedge clk) begin
            if (!rst_n)                 regs_q[g] <= '0;
            else if (wr_data && hit[g]) regs_q[g] <= io_wdata;
        end
    end

    always_comb begin
        sel_data = '1;
        for (int k = 0; k < NREG; k++)
            if (hit[k]) sel_data = regs_q[k];
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (io_addr == PORT_INDEX)     io_rdata = idx_q;
            else if (io_addr == PORT_DATA) io_rdata = sel_data;
        end
    end

    assign ctrl_c  = regs_q[0];
    assign ctrl_d  = regs_q[1];
    assign ctrl_ef = regs_q[2];

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_c == '0 && ctrl_d == '0 && ctrl_ef == '0 && idx_q == '0)); // R1
    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index |=> (idx_q == $past(io_wdata))); // R2
    AST_DATA_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && idx_q == reg_index(2)) |=> (ctrl_ef == $past(io_wdata))); // R3
    AST_UNIMPL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && hit == '0) |=> ($stable(ctrl_c) && $stable(ctrl_d) && $stable(ctrl_ef))); // R4
    AST_OTHER_PORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !wr_index && !wr_data) |=> ($stable(idx_q) && $stable(ctrl_c) && $stable(ctrl_d) && $stable(ctrl_ef))); // R12
endmodule

// File: rtl/shadow_slice_decode.sv
module shadow_slice_decode
    import shadow_pkg::*;
(
    input  logic [DW-1:0]   ctrl_c,
    input  logic [DW-1:0]   ctrl_d,
    input  logic [DW-1:0]   ctrl_ef,
    input  logic [MA_W-1:0] mem_addr,
    input  logic            mem_wr,
    output logic            mem_internal
);
    logic [NSLICE-1:0] rd_en, wr_en;
    logic              in_window;
    logic [SLICE_BITS-1:0] slice;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        localparam seg_e SEG = seg_e'(s / SLICES_PER_SEG);
        localparam int   SL  = s % SLICES_PER_SEG;
        if (SEG == SEG_C) begin : g_c
            assign rd_en[s] = ctrl_c[2*SL];
            assign wr_en[s] = ctrl_c[2*SL+1];
        end else if (SEG == SEG_D) begin : g_d
            assign rd_en[s] = ctrl_d[2*SL];
            assign wr_en[s] = ctrl_d[2*SL+1];
        end else if (SEG == SEG_E) begin : g_e
            assign rd_en[s] = ctrl_ef[0];
            assign wr_en[s] = ctrl_ef[1];
        end else begin : g_f
            assign rd_en[s] = ctrl_ef[2];
            assign wr_en[s] = ctrl_ef[3];
        end
    end

    assign in_window = (mem_addr[MA_W-1 -: 2] == 2'b11);
    assign slice     = mem_addr[SLICE_LSB +: SLICE_BITS];

    always_comb begin
        if (!in_window)  mem_internal = 1'b1;
        else if (mem_wr) mem_internal = wr_en[slice];
        else             mem_internal = rd_en[slice];
    end
endmodule

// File: rtl/shadow_window_top.sv
module shadow_window_top
    import shadow_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IOA_W-1:0] io_addr,
    input  logic [DW-1:0]    io_wdata,
    output logic [DW-1:0]    io_rdata,
    input  logic [MA_W-1:0]  mem_addr,
    input  logic             mem_wr,
    output logic             mem_internal
);
    logic [DW-1:0] ctrl_c, ctrl_d, ctrl_ef;

    shadow_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ctrl_c(ctrl_c), .ctrl_d(ctrl_d), .ctrl_ef(ctrl_ef)
    );

    shadow_slice_decode u_dec (
        .ctrl_c(ctrl_c), .ctrl_d(ctrl_d), .ctrl_ef(ctrl_ef),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_internal(mem_internal)
    );

    AST_LOW_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < 20'hC0000) |-> mem_internal); // R9
    AST_ZERO_CTRL_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_c == '0 && ctrl_d == '0 && ctrl_ef == '0 && mem_addr >= 20'hC0000) |-> !mem_internal); // R1
    AST_E_SEG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[19:16] == 4'hE && !mem_wr) |-> (mem_internal == ctrl_ef[0])); // R5
    AST_F_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[19:16] == 4'hF && mem_wr) |-> (mem_internal == ctrl_ef[3])); // R6
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (io_rdata == '0)); // R11
endmodule

// File: tb/tb_shadow_window_top.sv
module tb_shadow_window_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = '0;
    logic        mem_wr = 1'b0;
    logic        mem_internal;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    shadow_window_top dut (.*);

    // {req, index, value, address, write, expected}
    localparam int NV = 14;
    localparam logic [41:0] VEC [NV] = '{
        {4'd5, 8'h06, 8'h01, 20'hE1234, 1'b0, 1'b1},  // R5
        {4'd5, 8'h06, 8'h01, 20'hE1234, 1'b1, 1'b0},  // R5
        {4'd5, 8'h06, 8'h02, 20'hEFFFF, 1'b1, 1'b1},  // R5
        {4'd5, 8'h06, 8'h02, 20'hE0000, 1'b0, 1'b0},  // R5
        {4'd6, 8'h06, 8'h04, 20'hF0000, 1'b0, 1'b1},  // R6
        {4'd6, 8'h06, 8'h08, 20'hFFFFF, 1'b1, 1'b1},  // R6
        {4'd6, 8'h06, 8'h08, 20'hFFFFF, 1'b0, 1'b0},  // R6
        {4'd7, 8'h04, 8'h04, 20'hC4000, 1'b0, 1'b1},  // R7
        {4'd7, 8'h04, 8'h04, 20'hC0000, 1'b0, 1'b0},  // R7
        {4'd7, 8'h04, 8'h80, 20'hCFFFF, 1'b1, 1'b1},  // R7
        {4'd7, 8'h04, 8'h80, 20'hCC000, 1'b0, 1'b0},  // R7
        {4'd8, 8'h05, 8'h10, 20'hD8000, 1'b0, 1'b1},  // R8
        {4'd8, 8'h05, 8'h10, 20'hC8000, 1'b0, 1'b0},  // R8
        {4'd8, 8'h05, 8'h02, 20'hD0000, 1'b1, 1'b1}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        io_write(16'h0022, idx);
        io_read(16'h0024, d);
    endtask

    task automatic mem_probe(input logic [19:0] a, input logic w, output logic r);
        @(negedge clk);
        mem_addr = a; mem_wr = w;
        #1 r = mem_internal;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        io_read(16'h0022, d);   check("R1 index", d, 8'h00);
        reg_read(8'h06, d);     check("R1 reg6", d, 8'h00);
        reg_read(8'h04, d);     check("R1 reg4", d, 8'h00);
        mem_probe(20'hF0000, 1'b0, r); check("R1 F read ext", r, 0);
        mem_probe(20'hC0000, 1'b1, r); check("R1 C write ext", r, 0);

        // R11: idle read data
        @(negedge clk); io_addr = 16'h0022; io_rd = 1'b0;
        #1 check("R11 idle rdata", io_rdata, 8'h00);
        io_read(16'h0030, d);   check("R11 other port", d, 8'h00);

        // Vector table: R5 R6 R7 R8, and R10 through paired rows
        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            io_write(16'h0022, v[37:30]);
            io_write(16'h0024, v[29:22]);
            mem_probe(v[21:2], v[1], r);
            check($sformatf("R%0d vec%0d", v[41:38], i), r, v[0]);
        end

        // R3 read-back and R2 index read
        reg_read(8'h05, d);     check("R3 reg5 readback", d, 8'h02);
        io_read(16'h0022, d);   check("R2 index readback", d, 8'h05);

        // R10: the same cycle decodes read and write separately
        io_write(16'h0022, 8'h06);
        io_write(16'h0024, 8'h01);
        mem_probe(20'hE8000, 1'b0, r); check("R10 read same addr", r, 1);
        #1 mem_wr = 1'b1;
        #1 check("R10 write same addr", mem_internal, 0);

        // R9: low memory is always internal
        mem_probe(20'h12345, 1'b0, r); check("R9 low read", r, 1);
        mem_probe(20'hBFFFF, 1'b1, r); check("R9 low write", r, 1);

        // R4: unimplemented index
        reg_read(8'h07, d);     check("R4 unimpl read", d, 8'hFF);
        io_write(16'h0024, 8'hAB);
        reg_read(8'h06, d);     check("R4 reg6 kept", d, 8'h01);
        reg_read(8'h04, d);     check("R4 reg4 kept", d, 8'h80);
        reg_read(8'h05, d);     check("R4 reg5 kept", d, 8'h02);

        // R12: writes to other ports ignored
        io_write(16'h0025, 8'hFF);
        io_write(16'h0023, 8'h04);
        reg_read(8'h06, d);     check("R12 reg6 kept", d, 8'h01);
        mem_probe(20'hE0000, 1'b1, r); check("R12 decode kept", r, 0);

        // R1: reset after use clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_read(8'h04, d);     check("R1 reg4 after reset", d, 8'h00);
        mem_probe(20'hE0000, 1'b0, r); check("R1 E ext after reset", r, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule